// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller sits between a set of interrupt request lines and one processor interrupt input. Each line has its own priority value. A rising edge on a line is captured into a pending bit. The controller picks the most urgent pending line and asserts one request to the processor. When the processor acknowledges, the controller returns the index of the granted line as a vector and records that line's priority on an in-service stack.

There are two service disciplines. In sequential mode, nothing new is forwarded while any service is active; pending lines wait and are taken one at a time after each end-of-interrupt. In nested mode, a pending line whose priority is strictly above the level on top of the in-service stack is forwarded at once and preempts the running handler. Each end-of-interrupt strobe pops one level, so service returns to the level that was interrupted. Lower or equal arrivals wait until every level at or above them has been retired.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0, the in-service stack is empty and no line is pending.
- R2: A 0-to-1 transition on `req_i[i]` sets pending bit i. A pulse one clock long is enough. A line held high is latched only once, so after it is acknowledged it does not become pending again until it falls and rises again.
- R3: Among pending lines, the one with the largest 3-bit priority (`prio_cfg_i[3*i+2:3*i]`) is chosen, and on a tie the lower line index is chosen. `vec_o` shows the binary index of the granted line from the clock after the acknowledge until the next accepted acknowledge.
- R4: An acknowledge (`ack_i` high at a clock edge while `irq_o` is high) clears the granted line's pending bit and pushes its priority onto the stack. An `ack_i` while `irq_o` is low has no effect.
- R5: With the stack empty, `irq_o` is high whenever any line is pending.
- R6: In sequential mode (`nest_mode_i` = 0), `irq_o` stays low while the stack is not empty, whatever the priorities of the pending lines.
- R7: In nested mode (`nest_mode_i` = 1), a pending line with priority strictly greater than the top-of-stack priority raises `irq_o` while the lower service is active.
- R8: In nested mode, a pending line whose priority is equal to or less than the top-of-stack priority is held until end-of-interrupt strobes bring the top below it or empty the stack.
- R9: `eoi_i` pops one level, so service returns to the preempted level. With priorities 2, 4 and 5 and arrivals 2, then 5, then 4, the services end in the order 5, 4, 2. `eoi_i` on an empty stack has no effect.
- R10: A change of `nest_mode_i` takes effect only while the stack is empty. While any level is in service, the mode in force when the stack was last empty stays in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines, latched on rising edge |
| prio_cfg_i | input | 24 | Priority per line, 3 bits each, line i at bits 3i+2..3i |
| nest_mode_i | input | 1 | 1 = nested preemption, 0 = sequential service |
| ack_i | input | 1 | Processor acknowledge of the current request |
| eoi_i | input | 1 | End-of-interrupt strobe, retires the top service level |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Index of the most recently granted line |

## Verification
The hardest state to reach is a preemption chain: a low level in service, a higher level that has preempted it, and a third arrival that lies between the two and must wait for exactly one end-of-interrupt. The stimulus builds this in the order the requirement gives. It acknowledges each forwarded line before the next arrives, and it checks `irq_o` and `vec_o` after every strobe, so the return order can be seen at the ports. A mode flip during service is reached the same way: one level is held in service, the mode input is changed, and a higher line is raised while that level is still in service.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
   typedef enum logic {
      SVC_SEQ  = 1'b0,
      SVC_NEST = 1'b1
   } svc_mode_e;
endpackage

// File: rtl/nirq_pend_latch.sv
module nirq_pend_latch #(
   parameter int unsigned N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req_i,
   input  logic [N_LINES-1:0] clr_i,
   output logic [N_LINES-1:0] pend_o
);
   logic [N_LINES-1:0] req_q;
   logic [N_LINES-1:0] rise;

   initial assert (N_LINES >= 2) else $error("N_LINES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_i;
   end

   assign rise = req_i & ~req_q;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend_o[i] <= 1'b0;
         else if (rise[i])  pend_o[i] <= 1'b1;
         else if (clr_i[i]) pend_o[i] <= 1'b0;
      end

      AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> pend_o[i]); // R2
      AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !rise[i]) |=> !pend_o[i]); // R4
   end
endmodule

// File: rtl/nirq_pick.sv
module nirq_pick #(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0]        pend_i,
   input  logic [N_LINES*PRIO_W-1:0] prio_cfg_i,
   output logic                      any_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]         prio_o
);
   logic [PRIO_W-1:0] prio_arr [N_LINES];

   initial assert (PRIO_W >= 1) else $error("PRIO_W must be at least 1");

   for (genvar i = 0; i < N_LINES; i++) begin : g_unpack
      assign prio_arr[i] = prio_cfg_i[i*PRIO_W +: PRIO_W];
   end

   // strict greater-than keeps the lower index on a tie
   always_comb begin
      any_o  = 1'b0;
      idx_o  = '0;
      prio_o = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (pend_i[i] && (!any_o || prio_arr[i] > prio_o)) begin
            any_o  = 1'b1;
            idx_o  = IDX_W'(i);
            prio_o = prio_arr[i];
         end
      end
   end
endmodule

// File: rtl/nirq_lvl_stack.sv
module nirq_lvl_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [PRIO_W-1:0] push_val_i,
   output logic [PRIO_W-1:0] top_o,
   output logic              empty_o,
   output logic              full_o
);
   logic [PRIO_W-1:0] mem [DEPTH];
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     cnt_m1;
   logic [CW-1:0]     wr_ptr;
   logic              do_wr;

   initial assert (DEPTH >= 2) else $error("DEPTH must be at least 2");

   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == CW'(DEPTH));
   assign cnt_m1  = cnt - CW'(1);
   assign top_o   = empty_o ? '0 : mem[cnt_m1[AW-1:0]];

   // a pop with a push replaces the top entry
   assign do_wr  = push_i && (pop_i ? !empty_o : !full_o);
   assign wr_ptr = pop_i ? cnt_m1 : cnt;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem[e] <= '0;
         else if (do_wr && wr_ptr == CW'(e))   mem[e] <= push_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (push_i && !pop_i && !full_o) cnt <= cnt + CW'(1);
      else if (pop_i && !push_i && !empty_o) cnt <= cnt_m1;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> !full_o); // R4
   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !full_o) |=> (top_o == $past(push_val_i))); // R9
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int unsigned N_LINES     = 8,
   parameter int unsigned PRIO_W      = 3,
   parameter int unsigned STACK_DEPTH = 8,
   localparam int unsigned IDX_W      = $clog2(N_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_LINES-1:0]        req_i,
   input  logic [N_LINES*PRIO_W-1:0] prio_cfg_i,
   input  logic                      nest_mode_i,
   input  logic                      ack_i,
   input  logic                      eoi_i,
   output logic                      irq_o,
   output logic [IDX_W-1:0]          vec_o
);
   import nirq_pkg::*;

   logic [N_LINES-1:0] pend;
   logic [N_LINES-1:0] clr;
   logic               cand_any;
   logic [IDX_W-1:0]   cand_idx;
   logic [PRIO_W-1:0]  cand_prio;
   logic [PRIO_W-1:0]  top_prio;
   logic               stk_empty;
   logic               stk_full;
   logic               ack_ok;
   logic               eoi_ok;
   svc_mode_e          mode_q;
   svc_mode_e          mode_eff;

   initial assert (STACK_DEPTH >= (1 << PRIO_W))
      else $error("STACK_DEPTH must hold one entry per priority level");

   nirq_pend_latch #(.N_LINES(N_LINES)) u_pend (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr), .pend_o(pend)
   );

   nirq_pick #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_pick (
      .pend_i(pend), .prio_cfg_i(prio_cfg_i),
      .any_o(cand_any), .idx_o(cand_idx), .prio_o(cand_prio)
   );

   nirq_lvl_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push_i(ack_ok), .pop_i(eoi_ok),
      .push_val_i(cand_prio), .top_o(top_prio),
      .empty_o(stk_empty), .full_o(stk_full)
   );

   // mode input is only sampled while nothing is in service
   assign mode_eff = stk_empty ? svc_mode_e'(nest_mode_i) : mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= SVC_SEQ;
      else        mode_q <= mode_eff;
   end

   assign irq_o  = cand_any &&
                   (stk_empty || (mode_eff == SVC_NEST && cand_prio > top_prio));
   assign ack_ok = ack_i && irq_o;
   assign eoi_ok = eoi_i && !stk_empty;
   assign clr    = ack_ok ? ({{(N_LINES-1){1'b0}}, 1'b1} << cand_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vec_o <= '0;
      else if (ack_ok) vec_o <= cand_idx;
   end

   AST_SEQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SVC_SEQ && !stk_empty) |-> !irq_o); // R6
   AST_NEST_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !stk_empty) |-> (cand_prio > top_prio)); // R7
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!stk_empty && !$past(stk_empty)) |-> $stable(mode_q)); // R10
   AST_FULL_UNREACHED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !stk_full); // R8
endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req = '0;
   logic [23:0] prio = '0;
   logic        nest = 1'b0;
   logic        ack = 1'b0;
   logic        eoi = 1'b0;
   logic        irq;
   logic [2:0]  vec;
   int          n_chk = 0;
   int          n_err = 0;

   always #2.5 clk = ~clk;

   nest_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .prio_cfg_i(prio),
      .nest_mode_i(nest), .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vec_o(vec)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_prio(int line, int p);
      prio[line*3 +: 3] = 3'(p);
   endtask

   task automatic pulse(int line);
      req[line] = 1'b1;
      step();
      req[line] = 1'b0;
   endtask

   task automatic do_ack();
      ack = 1'b1;
      step();
      ack = 1'b0;
   endtask

   task automatic do_eoi();
      eoi = 1'b1;
      step();
      eoi = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 vec after reset", int'(vec), 0);
      do_eoi();                       // R9 pop on empty stack ignored
      pulse(0);
      chk("R9/R5 empty eoi ignored, irq", int'(irq), 1);
      do_ack();
      chk("R3 vec line0", int'(vec), 0);
      do_eoi();
      chk("R1 idle again", int'(irq), 0);
   endtask

   task automatic t_pick();
      nest = 1'b0;
      set_prio(0, 3); set_prio(1, 5); set_prio(2, 5); set_prio(3, 1);
      req[3:0] = 4'hF;
      step();
      req[3:0] = 4'h0;
      chk("R5 irq with pending", int'(irq), 1);
      do_ack(); chk("R3 tie lower index", int'(vec), 1);
      do_eoi(); do_ack(); chk("R3 second of tie", int'(vec), 2);
      do_eoi(); do_ack(); chk("R3 next priority", int'(vec), 0);
      do_eoi(); do_ack(); chk("R3 lowest priority", int'(vec), 3);
      do_eoi();
      chk("R4 all pending cleared", int'(irq), 0);
   endtask

   task automatic t_edge();
      set_prio(4, 2); set_prio(5, 6);
      req[4] = 1'b1;
      step();
      do_ack(); chk("R2 held line granted", int'(vec), 4);
      do_eoi(); step(); step();
      chk("R2 held level not relatched", int'(irq), 0);
      req[4] = 1'b0;
      do_ack();                       // spurious, irq low
      chk("R4 spurious ack vec unchanged", int'(vec), 4);
      pulse(5);
      chk("R4 spurious ack did not push", int'(irq), 1);
      do_ack(); chk("R4 vec line5", int'(vec), 5);
      do_eoi();
      chk("R4 stack empty after one eoi", int'(irq), 0);
   endtask

   task automatic t_seq();
      nest = 1'b0;
      set_prio(1, 2); set_prio(2, 4); set_prio(3, 5);
      pulse(1); do_ack();
      pulse(3);
      chk("R6 higher held in sequential", int'(irq), 0);
      do_eoi();
      chk("R6 released after eoi", int'(irq), 1);
      do_ack(); chk("R6 vec line3", int'(vec), 3);
      do_eoi();
      chk("R6 idle", int'(irq), 0);
   endtask

   task automatic t_nest();
      nest = 1'b1;
      set_prio(1, 2); set_prio(2, 4); set_prio(3, 5); set_prio(4, 5);
      pulse(1); do_ack(); chk("R7 printer granted", int'(vec), 1);
      pulse(3);
      chk("R7 higher preempts", int'(irq), 1);
      do_ack(); chk("R7 comm granted", int'(vec), 3);
      pulse(2);
      chk("R8 disk held below comm", int'(irq), 0);
      do_eoi();
      chk("R9 disk after comm ends", int'(irq), 1);
      do_ack(); chk("R9 disk granted", int'(vec), 2);
      do_eoi();
      chk("R9 back at printer level", int'(irq), 0);
      pulse(2);
      chk("R9 printer level still active", int'(irq), 1);
      do_ack(); do_eoi();
      do_eoi();
      chk("R9 stack empty", int'(irq), 0);
      pulse(3); do_ack();
      pulse(4);
      chk("R8 equal priority held", int'(irq), 0);
      do_eoi();
      chk("R8 equal released", int'(irq), 1);
      do_ack(); chk("R8 vec line4", int'(vec), 4);
      do_eoi();
   endtask

   task automatic t_mode();
      nest = 1'b1;
      set_prio(6, 1); set_prio(7, 6);
      pulse(6); do_ack();
      nest = 1'b0;
      pulse(7);
      chk("R10 nested kept during service", int'(irq), 1);
      do_ack(); chk("R10 vec line7", int'(vec), 7);
      do_eoi(); do_eoi();
      pulse(6); do_ack();
      pulse(7);
      chk("R10 sequential after empty", int'(irq), 0);
      do_eoi();
      chk("R10 line7 after eoi", int'(irq), 1);
      do_ack(); chk("R10 vec line7 again", int'(vec), 7);
      do_eoi();
   endtask

   initial begin
      #1000000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_pick();
      t_edge();
      t_seq();
      t_nest();
      t_mode();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule